// File: doc/BRIEF.md
# Quad-Lane Serial Sample Framer

This block turns four parallel sample words per sample period into four serial bit streams, one per channel, together with a shared bit clock and a word-frame marker. It runs on a single fast clock at the serial bit rate. With 12-bit words that clock runs at twelve times the sample rate. The block produces its own capture strobe, so upstream logic knows in which cycle the four words are taken.

Each captured word set passes through a latency line of nine sample periods before it is serialised. Every lane then sends its word most significant bit first over twelve fast-clock cycles. The bit clock output toggles on every running cycle, so it runs at six times the sample rate and each of its edges carries a new bit. The frame marker is a square wave at the sample rate whose rising edge coincides with each MSB.

Two control inputs set the running state. When the clock-generator lock input is low, the whole block freezes: outputs, counters and the latency line all hold. When the power-down input is high, the outputs are driven low, the bit counter restarts and the latency line is emptied. Power-down overrides the lock input.

Top module: `quad_serial_framer`

## Requirements
- R1: While `rst` is high, and in the cycle after it has been high, `lane_o`, `dclk_o` and `frame_o` are 0 and `cap_o` is 1.
- R2: In each running cycle (`pwr_down`=0, `pll_locked`=1), `dclk_o` inverts at the next edge. It is 1 while the MSB of a word is on the lanes, so bit k of a word (k=0 is the MSB) is presented with `dclk_o` = 1 for even k and 0 for odd k.
- R3: `frame_o` is 1 during bits 0 to 5 of each word and 0 during bits 6 to 11, so its rising edge falls on each MSB.
- R4: Lane l carries the word `samp_i[l*12 +: 12]` on `lane_o[l]`, MSB first, one bit per running cycle, with each lane independent of the others.
- R5: A word set captured at one word boundary appears on the lanes starting at the ninth following word boundary. The nine word periods after reset or power-down send all-zero words.
- R6: `cap_o` is 1 in exactly one cycle of each 12, the cycle in which bit 11 is on the lanes. `samp_i` is captured at the rising edge that ends a cycle with `cap_o`=1, provided the block is running.
- R7: While `pll_locked`=0 and `pwr_down`=0, all outputs hold their values and no capture happens. On release, the word continues from the bit where it stopped.
- R8: One edge after `pwr_down` is raised, `lane_o`, `dclk_o` and `frame_o` are 0 and `cap_o` is 1, whatever the value of `pll_locked`. The latency line is emptied, so after release zeros are sent first, as in R5.
- R9: Sample codes pass bit-exact in offset binary form: 0x000 (negative full scale), 0x800 (midscale) and 0xFFF (positive full scale) come out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| pll_locked | input | 1 | Clock generator lock; low freezes the block |
| pwr_down | input | 1 | Power-down; high drives the outputs low and flushes the block |
| samp_i | input | 48 | Four 12-bit samples, lane l at bits l*12 +: 12 |
| lane_o | output | 4 | Serial data, one bit per lane |
| dclk_o | output | 1 | Bit clock, one toggle per bit |
| frame_o | output | 1 | Frame marker, high for the first half of each word |
| cap_o | output | 1 | High in the last bit cycle; samples are taken at its closing edge |

## Verification
The bench targets the word boundary, the nine-period latency, the lock freeze and power-down. It freezes the block at bit 11 while driving garbage onto `samp_i`. A design that captured during the freeze would then send the garbage nine words later. A freeze in mid-word checks that the bit position, the bit-clock phase and the frame phase all resume where they stopped; a counter that kept running would shift every later bit. The bench raises power-down with the lock input low to test the priority, then checks that nine zero words come out before fresh data. A design that did not empty the latency line would instead replay stale samples. Words at full scale, midscale and in alternating patterns catch a reversed bit order or swapped lanes.

// File: rtl/qsf_pkg.sv
package qsf_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_OFF  = 2'd2
  } qsf_mode_e;

  // Power-down wins over the lock input.
  function automatic qsf_mode_e qsf_mode(input logic locked, input logic pd);
    if (pd) return MODE_OFF;
    if (!locked) return MODE_HOLD;
    return MODE_RUN;
  endfunction

endpackage

// File: rtl/qsf_bit_timer.sv
module qsf_bit_timer
  import qsf_pkg::*;
#(
  parameter int WORD_BITS = 12
) (
  input  logic      clk,
  input  logic      rst,
  input  qsf_mode_e mode,
  output logic      wrap,
  output logic      dclk_o,
  output logic      frame_o,
  output logic      cap_o
);
  localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_BITS / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          dclk_q, frame_q, cap_q;

  assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || mode == MODE_OFF) begin
      cnt_q   <= LAST;
      dclk_q  <= 1'b0;
      frame_q <= 1'b0;
      cap_q   <= 1'b1;
    end else if (mode == MODE_RUN) begin
      cnt_q   <= cnt_nxt;
      dclk_q  <= ~dclk_q;
      frame_q <= (cnt_nxt < HALF);
      cap_q   <= (cnt_nxt == LAST);
    end
  end

  assign wrap    = (mode == MODE_RUN) && cap_q;
  assign dclk_o  = dclk_q;
  assign frame_o = frame_q;
  assign cap_o   = cap_q;

endmodule

// File: rtl/qsf_delay_line.sv
module qsf_delay_line #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else if (adv) begin
      stage_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // The oldest entry, read before this boundary's shift.
  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/qsf_lane_ser.sv
module qsf_lane_ser #(
  parameter int WORD_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 adv,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] word,
  output logic                 bit_o
);
  logic [WORD_BITS-1:0] sreg_q;
  logic                 bit_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sreg_q <= '0;
      bit_q  <= 1'b0;
    end else if (load) begin
      bit_q  <= word[WORD_BITS-1];
      sreg_q <= {word[WORD_BITS-2:0], 1'b0};
    end else if (adv) begin
      bit_q  <= sreg_q[WORD_BITS-1];
      sreg_q <= {sreg_q[WORD_BITS-2:0], 1'b0};
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/quad_serial_framer.sv
module quad_serial_framer
  import qsf_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SAMPLE_W  = 12,
  parameter int LATENCY   = 9
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pll_locked,
  input  logic                          pwr_down,
  input  logic [NUM_LANES*SAMPLE_W-1:0] samp_i,
  output logic [NUM_LANES-1:0]          lane_o,
  output logic                          dclk_o,
  output logic                          frame_o,
  output logic                          cap_o
);
  localparam int BUS_W = NUM_LANES * SAMPLE_W;

  qsf_mode_e        mode;
  logic             wrap, run, off;
  logic [BUS_W-1:0] tail;

  assign mode = qsf_mode(pll_locked, pwr_down);
  assign run  = (mode == MODE_RUN);
  assign off  = (mode == MODE_OFF);

  qsf_bit_timer #(.WORD_BITS(SAMPLE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .wrap    (wrap),
    .dclk_o  (dclk_o),
    .frame_o (frame_o),
    .cap_o   (cap_o)
  );

  qsf_delay_line #(.WIDTH(BUS_W), .DEPTH(LATENCY)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .flush (off),
    .adv   (wrap),
    .din   (samp_i),
    .dout  (tail)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    qsf_lane_ser #(.WORD_BITS(SAMPLE_W)) u_ser (
      .clk   (clk),
      .rst   (rst),
      .flush (off),
      .adv   (run),
      .load  (wrap),
      .word  (tail[l*SAMPLE_W +: SAMPLE_W]),
      .bit_o (lane_o[l])
    );
  end

endmodule

// File: rtl/qsf_checker.sv
module qsf_checker #(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pll_locked,
  input logic                 pwr_down,
  input logic [NUM_LANES-1:0] lane_o,
  input logic                 dclk_o,
  input logic                 frame_o,
  input logic                 cap_o
);

  assert_dclk_toggles_R2: assert property (@(posedge clk) disable iff (rst)
    (pll_locked && !pwr_down) |=> (dclk_o != $past(dclk_o)));

  assert_frame_rise_on_msb_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_o) |-> dclk_o);

  assert_cap_in_low_half_R6: assert property (@(posedge clk) disable iff (rst)
    cap_o |-> !frame_o);

  assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!pll_locked && !pwr_down) |=>
      ($stable(lane_o) && $stable(dclk_o) && $stable(frame_o) && $stable(cap_o)));

  assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (lane_o == '0 && !dclk_o && !frame_o && cap_o));

endmodule

bind quad_serial_framer qsf_checker #(.NUM_LANES(NUM_LANES)) u_qsf_chk (
  .clk        (clk),
  .rst        (rst),
  .pll_locked (pll_locked),
  .pwr_down   (pwr_down),
  .lane_o     (lane_o),
  .dclk_o     (dclk_o),
  .frame_o    (frame_o),
  .cap_o      (cap_o)
);

// File: tb/tb_quad_serial_framer.sv
module tb_quad_serial_framer;
  localparam int NL   = 4;
  localparam int SW   = 12;
  localparam int LAT  = 9;
  localparam int HALF = SW / 2;
  localparam int BW   = NL * SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pll_locked = 1'b1;
  logic          pwr_down = 1'b0;
  logic [BW-1:0] samp_i = '0;
  logic [NL-1:0] lane_o;
  logic          dclk_o, frame_o, cap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [BW-1:0] model [LAT];

  always #5 clk = ~clk;

  quad_serial_framer #(.NUM_LANES(NL), .SAMPLE_W(SW), .LATENCY(LAT)) dut (
    .clk(clk), .rst(rst), .pll_locked(pll_locked), .pwr_down(pwr_down),
    .samp_i(samp_i), .lane_o(lane_o), .dclk_o(dclk_o), .frame_o(frame_o), .cap_o(cap_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [BW-1:0] pat(input int seed, input int w);
    logic [BW-1:0] v;
    for (int l = 0; l < NL; l++)
      v[l*SW +: SW] = SW'((seed * 131 + w * 37 + l * 291) ^ 12'h5A3);
    return v;
  endfunction

  task automatic flush_model();
    for (int i = 0; i < LAT; i++) model[i] = '0;
  endtask

  task automatic freeze_hold(input bit at_cap);
    logic [NL-1:0] l0; logic d0, f0, c0; logic [BW-1:0] keep;
    l0 = lane_o; d0 = dclk_o; f0 = frame_o; c0 = cap_o; keep = samp_i;
    pll_locked = 1'b0;
    if (at_cap) samp_i = ~keep;
    repeat (5) begin
      @(posedge clk); @(negedge clk);
      chk(lane_o == l0 && dclk_o == d0 && frame_o == f0 && cap_o == c0, "R7 freeze hold",
          {lane_o, dclk_o, frame_o, cap_o}, {l0, d0, f0, c0});
    end
    samp_i = keep;
    pll_locked = 1'b1;
  endtask

  // Called at a negedge with cap_o=1; drives one word set, checks one word period.
  task automatic send_word(input logic [BW-1:0] word, input int frz_bit);
    logic [BW-1:0] exp_w;
    logic [SW-1:0] obs [NL];
    exp_w = model[LAT-1];
    for (int i = LAT - 1; i > 0; i--) model[i] = model[i-1];
    model[0] = word;
    samp_i = word;
    for (int b = 0; b < SW; b++) begin
      @(posedge clk); @(negedge clk);
      for (int l = 0; l < NL; l++) obs[l] = {obs[l][SW-2:0], lane_o[l]};
      chk(frame_o == (b < HALF), "R3 frame phase", 64'(frame_o), 64'(b < HALF));
      chk(dclk_o == (b % 2 == 0), "R2 bit clock phase", 64'(dclk_o), 64'(b % 2 == 0));
      chk(cap_o == (b == SW - 1), "R6 capture strobe", 64'(cap_o), 64'(b == SW - 1));
      if (b == frz_bit) freeze_hold(b == SW - 1);
    end
    for (int l = 0; l < NL; l++)
      chk(obs[l] == exp_w[l*SW +: SW], "R4 R5 R9 lane word", 64'(obs[l]), 64'(exp_w[l*SW +: SW]));
  endtask

  task automatic t_reset();
    rst = 1'b1; pll_locked = 1'b1; pwr_down = 1'b0; samp_i = pat(7, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lane_o == '0 && !dclk_o && !frame_o && cap_o, "R1 reset state",
        {lane_o, dclk_o, frame_o, cap_o}, {4'b0, 3'b001});
    rst = 1'b0;
    flush_model();
  endtask

  task automatic t_stream(input int seed, input int n);
    for (int w = 0; w < n; w++) send_word(pat(seed, w), -1);
  endtask

  task automatic t_codes();
    send_word({12'h000, 12'hFFF, 12'h800, 12'h7FF}, -1);
    send_word({12'hFFF, 12'h000, 12'hAAA, 12'h555}, -1);
    send_word({12'h800, 12'h800, 12'h001, 12'hFFE}, -1);
    t_stream(3, LAT);
  endtask

  task automatic t_freeze();
    send_word(pat(11, 0), 3);
    send_word(pat(11, 1), SW - 1);
    send_word(pat(11, 2), 0);
    send_word(pat(11, 3), 8);
    t_stream(12, LAT);
  endtask

  task automatic t_pwrdown();
    samp_i = pat(21, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    pwr_down = 1'b1; pll_locked = 1'b0;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk(lane_o == '0 && !dclk_o && !frame_o && cap_o, "R8 power-down outputs",
          {lane_o, dclk_o, frame_o, cap_o}, {4'b0, 3'b001});
    end
    pwr_down = 1'b0; pll_locked = 1'b1;
    flush_model();
    t_stream(22, LAT + 3);
  endtask

  initial begin
    t_reset();
    t_stream(1, LAT + 4);
    t_codes();
    t_freeze();
    t_pwrdown();
    t_reset();
    t_stream(5, LAT + 2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule